// File: doc/BRIEF.md
# Event Performance Monitor

This block counts processor activity for profiling. It has three 32-bit counters. Counter 0 counts clock cycles only. Counters 1 and 2 each count one event line, picked by an 8-bit event code. Event lines arrive as a vector of single-cycle pulses.

A single control word holds everything that steers the counters:
- a global run bit;
- two self-clearing reset bits;
- a cycle pre-divider;
- per-counter interrupt enables;
- sticky overflow flags;
- the two event codes.

No counter has its own run bit. A configurable counter is stopped by selecting code 0x20, which matches no live event line. The cycle counter is "turned off" only by masking its interrupt.

Software reaches the control word and the three counters through a small synchronous write / combinational read port. Each flag clears when a 1 is written to its bit. Because of this, writing back a control value that was just read clears every flag that was set and leaves every other field unchanged. One level-sensitive interrupt reports any flagged overflow whose interrupt enable is set.

Top module: `evmon_top`

## Requirements
- R1: After reset, all three counters, every control field and every flag read as zero, and irqOut is low.
- R2: Control bit 0 is the global run bit. While it is clear, no counter changes except by a direct write or a reset bit. While it is set and bit 3 is clear, the cycle counter advances by one on every clock.
- R3: With control bit 3 set, the cycle counter advances once per 64 running clocks. A 6-bit prescaler does the division. It starts from zero at reset and is cleared by the cycle reset bit. It advances only on running clocks.
- R4: Writing 1 to control bit 1 zeroes both event counters. Writing 1 to control bit 2 zeroes the cycle counter. Both bits read back as 0. A direct write to a counter loads that value. A direct write or a reset bit takes precedence over an increment in the same cycle.
- R5: Event counter 1 uses the code in control bits 27:20, and event counter 2 uses the code in bits 19:12. A code c in 0x00–0x12, other than 0x08 and 0x0E, counts the pulses on eventPulse[c] while the run bit is set. Any other code counts nothing, and eventPulse[8] and eventPulse[14] are never counted.
- R6: When a counter wraps from 0xFFFFFFFF to 0, its sticky flag is set on that same edge. The flags are bit 8 (event counter 1), bit 9 (event counter 2) and bit 10 (cycle counter).
- R7: Writing 1 to a flag bit clears it, and writing 0 to it leaves it unchanged. Writing back a value just read clears the set flags and keeps every other field.
- R8: Code 0x20 parks an event counter: it holds its value even while every event line pulses.
- R9: irqOut is high exactly when some flag is set together with its interrupt enable. The enables are bit 4 (event counter 1), bit 5 (event counter 2) and bit 6 (cycle counter).
- R10: If a flag clear coincides with a new wrap of the same counter, the flag ends up set.
- R11: The register addresses are 0 for the control word, 1 for the cycle counter, 2 for event counter 1 and 3 for event counter 2. A read returns the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register address for read and write |
| regWrEn | input | 1 | Write strobe, applied at the rising edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| eventPulse | input | NUM_LINES (19) | Single-cycle event pulses, one line per event code |
| irqOut | output | 1 | Level interrupt for enabled overflow flags |

## Verification
The bench drives counters close to 0xFFFFFFFF and lets them wrap. A design that flags one edge late, or that never sets the flag, diverges in the flag bits and in irqOut.

It times a flag clear onto the very edge of a new wrap. A design that lets the clear win loses that overflow.

It writes back the control word it just read. A design with plain read/write flags, or with reset bits that read back as 1, either keeps stale flags or wipes the counters.

It also pulses the two unsupported event lines and the parking code with every line active, to catch decoders that count holes. With the divider on, it checks the 64-clock cadence against a prescaler that pauses while the run bit is clear.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
  localparam int CNT_W = 32;
  localparam int SEL_W = 8;

  // Control word bit positions (software decodes these)
  localparam int B_RUN      = 0;
  localparam int B_CLR_EVT  = 1;
  localparam int B_CLR_CYC  = 2;
  localparam int B_DIV      = 3;
  localparam int B_IE_E0    = 4;
  localparam int B_IE_E1    = 5;
  localparam int B_IE_CYC   = 6;
  localparam int B_FLG_E0   = 8;
  localparam int B_FLG_E1   = 9;
  localparam int B_FLG_CYC  = 10;
  localparam int B_SEL1_LO  = 12;
  localparam int B_SEL0_LO  = 20;

  // Event codes that have no line behind them
  localparam logic [SEL_W-1:0] HOLE_A = 8'h08;
  localparam logic [SEL_W-1:0] HOLE_B = 8'h0E;

  // Strobes from control to datapath. Counter index: 0 cycle, 1 event0, 2 event1
  typedef struct packed {
    logic             enable;
    logic             divOn;
    logic             clrCycle;
    logic             clrEvt;
    logic [2:0]       loadCnt;
    logic [CNT_W-1:0] loadVal;
    logic [SEL_W-1:0] sel0;
    logic [SEL_W-1:0] sel1;
  } dpStrobe_t;
endpackage

// File: rtl/evmon_counter.sv
module evmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         incr,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] value,
  output logic         wrap
);
  // A load or clear takes precedence, so only a real increment can wrap
  assign wrap = incr && !clear && !load && (&value);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      value <= '0;
    else if (load)  value <= loadVal;
    else if (clear) value <= '0;
    else if (incr)  value <= value + 1'b1;
  end
endmodule

// File: rtl/evmon_datapath.sv
module evmon_datapath
  import evmon_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int DIV_LOG2  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            strobe,
  input  logic [NUM_LINES-1:0] eventPulse,
  output logic [CNT_W-1:0]     cntVal [3],
  output logic [2:0]           wrapHit
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int PAD_W = 2 ** IDX_W;

  logic [PAD_W-1:0]    padPulse;
  logic [DIV_LOG2-1:0] preCnt;
  logic                preTick;

  assign padPulse = PAD_W'(eventPulse);
  assign preTick  = &preCnt;

  function automatic logic eventHit(input logic [SEL_W-1:0] code,
                                    input logic [PAD_W-1:0] lines);
    if (code < SEL_W'(NUM_LINES) && code != HOLE_A && code != HOLE_B)
      return lines[code[IDX_W-1:0]];
    return 1'b0;
  endfunction

  // Cycle prescaler: paused while not running, cleared with the cycle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               preCnt <= '0;
    else if (strobe.clrCycle)                preCnt <= '0;
    else if (strobe.enable && strobe.divOn)  preCnt <= preCnt + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : gCnt
    logic incr;
    logic clr;
    if (g == 0) begin : gCycle
      assign incr = strobe.enable && (!strobe.divOn || preTick);
      assign clr  = strobe.clrCycle;
    end else begin : gEvent
      logic [SEL_W-1:0] sel;
      assign sel  = (g == 1) ? strobe.sel0 : strobe.sel1;
      assign incr = strobe.enable && eventHit(sel, padPulse);
      assign clr  = strobe.clrEvt;
    end
    evmon_counter #(.W(CNT_W)) uCnt (
      .clk     (clk),
      .rstN    (rstN),
      .incr    (incr),
      .clear   (clr),
      .load    (strobe.loadCnt[g]),
      .loadVal (strobe.loadVal),
      .value   (cntVal[g]),
      .wrap    (wrapHit[g])
    );
  end

  // R2: stopped and untouched counters hold
  a_r2_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.enable && strobe.loadCnt == 3'b000 && !strobe.clrCycle && !strobe.clrEvt)
    |=> ($stable(cntVal[0]) && $stable(cntVal[1]) && $stable(cntVal[2])));

  // R8: parking code holds event counter 1
  a_r8_parked: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.sel0 == 8'h20 && !strobe.loadCnt[1] && !strobe.clrEvt) |=> $stable(cntVal[1]));

  // R4: event reset bit zeroes both event counters
  a_r4_evt_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEvt |=> (cntVal[1] == '0 && cntVal[2] == '0));

  // R6: a wrap leaves the counter at zero
  a_r6_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit[0] |=> cntVal[0] == '0);
endmodule

// File: rtl/evmon_ctrl.sv
module evmon_ctrl
  import evmon_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       regAddr,
  input  logic             regWrEn,
  input  logic [31:0]      regWrData,
  output logic [31:0]      regRdData,
  input  logic [CNT_W-1:0] cntVal [3],
  input  logic [2:0]       wrapHit,
  output dpStrobe_t        strobe,
  output logic             irqOut
);
  logic             runReg;
  logic             divReg;
  logic [2:0]       ieReg;    // index 0 cycle, 1 event0, 2 event1
  logic [2:0]       flagReg;
  logic [SEL_W-1:0] sel0Reg;
  logic [SEL_W-1:0] sel1Reg;
  logic             wrCtl;
  logic [2:0]       w1cMask;
  logic [31:0]      ctrlWord;

  assign wrCtl   = regWrEn && (regAddr == 2'd0);
  assign w1cMask = wrCtl ? {regWrData[B_FLG_E1], regWrData[B_FLG_E0], regWrData[B_FLG_CYC]} : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runReg  <= 1'b0;
      divReg  <= 1'b0;
      ieReg   <= '0;
      sel0Reg <= '0;
      sel1Reg <= '0;
    end else if (wrCtl) begin
      runReg  <= regWrData[B_RUN];
      divReg  <= regWrData[B_DIV];
      ieReg   <= {regWrData[B_IE_E1], regWrData[B_IE_E0], regWrData[B_IE_CYC]};
      sel0Reg <= regWrData[B_SEL0_LO +: SEL_W];
      sel1Reg <= regWrData[B_SEL1_LO +: SEL_W];
    end
  end

  // New overflow wins over a coincident write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~w1cMask) | wrapHit;
  end

  always_comb begin
    strobe          = '0;
    strobe.enable   = runReg;
    strobe.divOn    = divReg;
    strobe.clrEvt   = wrCtl && regWrData[B_CLR_EVT];
    strobe.clrCycle = wrCtl && regWrData[B_CLR_CYC];
    for (int i = 0; i < 3; i++)
      strobe.loadCnt[i] = regWrEn && (regAddr == 2'(i + 1));
    strobe.loadVal  = regWrData;
    strobe.sel0     = sel0Reg;
    strobe.sel1     = sel1Reg;
  end

  always_comb begin
    ctrlWord                       = '0;
    ctrlWord[B_RUN]                = runReg;
    ctrlWord[B_DIV]                = divReg;
    ctrlWord[B_IE_E0]              = ieReg[1];
    ctrlWord[B_IE_E1]              = ieReg[2];
    ctrlWord[B_IE_CYC]             = ieReg[0];
    ctrlWord[B_FLG_E0]             = flagReg[1];
    ctrlWord[B_FLG_E1]             = flagReg[2];
    ctrlWord[B_FLG_CYC]            = flagReg[0];
    ctrlWord[B_SEL0_LO +: SEL_W]   = sel0Reg;
    ctrlWord[B_SEL1_LO +: SEL_W]   = sel1Reg;
  end

  always_comb begin
    case (regAddr)
      2'd0:    regRdData = ctrlWord;
      2'd1:    regRdData = cntVal[0];
      2'd2:    regRdData = cntVal[1];
      default: regRdData = cntVal[2];
    endcase
  end

  assign irqOut = |(flagReg & ieReg);

  // R10: a wrap always leaves its flag set
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    wrapHit[0] |=> flagReg[0]);

  // R7: a flag survives unless a 1 is written to its bit
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagReg[1] && !(wrCtl && regWrData[B_FLG_E0])) |=> flagReg[1]);

  // R9: the interrupt rises only after an overflow or a control write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(wrapHit) != 3'b000 || $past(wrCtl)));
endmodule

// File: rtl/evmon_top.sv
module evmon_top
  import evmon_pkg::*;
#(
  parameter int NUM_LINES = 19,
  parameter int DIV_LOG2  = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           regAddr,
  input  logic                 regWrEn,
  input  logic [31:0]          regWrData,
  output logic [31:0]          regRdData,
  input  logic [NUM_LINES-1:0] eventPulse,
  output logic                 irqOut
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntVal [3];
  logic [2:0]       wrapHit;

  evmon_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .cntVal    (cntVal),
    .wrapHit   (wrapHit),
    .strobe    (strobe),
    .irqOut    (irqOut)
  );

  evmon_datapath #(.NUM_LINES(NUM_LINES), .DIV_LOG2(DIV_LOG2)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .eventPulse (eventPulse),
    .cntVal     (cntVal),
    .wrapHit    (wrapHit)
  );
endmodule

// File: tb/evmon_top_test.sv
module evmon_top_test;
  localparam int LINES = 19;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       regAddr = '0;
  logic             regWrEn = 1'b0;
  logic [31:0]      regWrData = '0;
  logic [31:0]      regRdData;
  logic [LINES-1:0] eventPulse = '0;
  logic             irqOut;

  always #10 clk = ~clk;   // 50 MHz

  evmon_top uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .eventPulse(eventPulse),
    .irqOut(irqOut)
  );

  // Behavioural reference model
  bit [31:0] mCnt [3];
  bit        mRun, mDiv;
  bit [2:0]  mIe, mFlag;   // 0 cycle, 1 event0, 2 event1
  bit [7:0]  mSel0, mSel1;
  int        mPre;

  int    total = 0, bad = 0;
  string tag = "R1";
  int    evtMode = 0;      // 0 quiet, 1 random, 2 all lines
  bit    done = 1'b0;

  function automatic bit hit(bit [7:0] code, logic [LINES-1:0] p);
    if (code <= 8'h12 && code != 8'h08 && code != 8'h0E) return p[code];
    return 1'b0;
  endfunction

  function automatic int flagBit(int i);
    return (i == 0) ? 10 : (i == 1) ? 8 : 9;
  endfunction

  function automatic int ieBit(int i);
    return (i == 0) ? 6 : (i == 1) ? 4 : 5;
  endfunction

  function automatic bit [31:0] modelCtrl();
    bit [31:0] v = '0;
    v[0] = mRun;
    v[3] = mDiv;
    for (int i = 0; i < 3; i++) begin
      v[ieBit(i)]   = mIe[i];
      v[flagBit(i)] = mFlag[i];
    end
    v[27:20] = mSel0;
    v[19:12] = mSel1;
    return v;
  endfunction

  task automatic modelStep();
    bit        wrCtl = regWrEn && regAddr == 2'd0;
    bit [2:0]  inc, ovf;
    bit        clr;
    inc[0] = mRun && (!mDiv || mPre == 63);
    inc[1] = mRun && hit(mSel0, eventPulse);
    inc[2] = mRun && hit(mSel1, eventPulse);
    ovf = '0;
    for (int i = 0; i < 3; i++) begin
      clr = wrCtl && regWrData[(i == 0) ? 2 : 1];
      if (regWrEn && regAddr == 2'(i + 1)) mCnt[i] = regWrData;
      else if (clr) mCnt[i] = 0;
      else if (inc[i]) begin
        if (mCnt[i] == 32'hFFFF_FFFF) ovf[i] = 1'b1;
        mCnt[i] = mCnt[i] + 1;
      end
    end
    if (wrCtl && regWrData[2]) mPre = 0;
    else if (mRun && mDiv) mPre = (mPre + 1) % 64;
    for (int i = 0; i < 3; i++)
      mFlag[i] = (mFlag[i] && !(wrCtl && regWrData[flagBit(i)])) || ovf[i];
    if (wrCtl) begin
      mRun  = regWrData[0];
      mDiv  = regWrData[3];
      for (int i = 0; i < 3; i++) mIe[i] = regWrData[ieBit(i)];
      mSel0 = regWrData[27:20];
      mSel1 = regWrData[19:12];
    end
  endtask

  task automatic compare();
    bit [31:0] expRd  = (regAddr == 2'd0) ? modelCtrl() : mCnt[regAddr - 1];
    bit        expIrq = |(mFlag & mIe);
    total++;
    if (regRdData !== expRd) begin
      bad++;
      $display("FAIL %s/R11 addr=%0d actual=%h expected=%h", tag, regAddr, regRdData, expRd);
    end
    total++;
    if (irqOut !== expIrq) begin
      bad++;
      $display("FAIL %s/R9 irqOut actual=%b expected=%b", tag, irqOut, expIrq);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rstN) modelStep();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      regWrEn = 1'b0;
      regAddr = 2'(k % 4);
      eventPulse = (evtMode == 0) ? '0 : (evtMode == 2) ? '1 : LINES'($urandom);
      step();
    end
  endtask

  task automatic wr(bit [1:0] a, bit [31:0] d);
    regWrEn = 1'b1;
    regAddr = a;
    regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  localparam bit [31:0] RUN = 32'h1;

  initial begin
    bit [31:0] rb;
    mRun = 0; mDiv = 0; mIe = 0; mFlag = 0; mSel0 = 0; mSel1 = 0; mPre = 0;
    for (int i = 0; i < 3; i++) mCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state across all four addresses
    tag = "R1";  idle(8);
    // R2: cycle counter runs every clock, then freezes
    tag = "R2";  wr(0, RUN); idle(20);
    wr(0, 0); evtMode = 2; idle(8);
    // R5: event selection with random and full pulse patterns
    tag = "R5";  evtMode = 1; wr(0, RUN | (32'h07 << 20) | (32'h0B << 12)); idle(40);
    evtMode = 2; wr(0, RUN | (32'h08 << 20) | (32'h0E << 12)); idle(10);
    evtMode = 1; wr(0, RUN | (32'h12 << 20) | (32'h00 << 12)); idle(30);
    wr(0, RUN | (32'h13 << 20) | (32'h0F << 12)); idle(20);
    // R8: parked counters hold under full activity
    tag = "R8";  evtMode = 2; wr(0, RUN | (32'h20 << 20) | (32'h20 << 12)); idle(12);
    // R4: reset bits and direct loads versus increments
    tag = "R4";  wr(0, RUN | 32'h2 | (32'h01 << 20) | (32'h02 << 12)); idle(4);
    wr(0, RUN | 32'h4 | (32'h01 << 20) | (32'h02 << 12)); idle(4);
    wr(2, 32'h55); wr(1, 0); wr(3, 32'h1234_5678); idle(4);
    // R3: divided cycle counting, with a pause and a prescaler clear
    tag = "R3";  evtMode = 0; wr(0, RUN | 32'h8); idle(150);
    wr(0, 32'h8); idle(10); wr(0, RUN | 32'h8 | 32'h4); idle(140);
    // R6 / R9: event counter 1 wraps with its interrupt enabled
    tag = "R6";  evtMode = 2; wr(0, RUN | (32'h05 << 20) | (32'h20 << 12) | (32'h1 << 4));
    wr(2, 32'hFFFF_FFFC); idle(8);
    // R7: writing 0 keeps the flag, writeback clears it and keeps fields
    tag = "R7";  wr(0, RUN | (32'h05 << 20) | (32'h20 << 12) | (32'h1 << 4)); idle(2);
    regAddr = 2'd0; eventPulse = '0; step(); rb = regRdData;
    wr(0, rb); idle(4);
    // R10: clear coincides with a fresh wrap
    tag = "R10"; wr(2, 32'hFFFF_FFFC); idle(6);
    wr(2, 32'hFFFF_FFFE); eventPulse = '1; regAddr = 2'd0; step();
    wr(0, RUN | (32'h05 << 20) | (32'h20 << 12) | (32'h1 << 4) | (32'h1 << 8)); idle(4);
    // R9: event counter 2 and cycle counter overflows, enables toggled
    tag = "R9";  wr(0, RUN | (32'h20 << 20) | (32'h12 << 12));
    wr(3, 32'hFFFF_FFF8); idle(12);
    wr(0, RUN | (32'h20 << 20) | (32'h12 << 12) | (32'h1 << 5)); idle(4);
    wr(0, RUN | (32'h20 << 20) | (32'h20 << 12) | (32'h1 << 6) | (32'h7 << 8));
    wr(1, 32'hFFFF_FFF0); idle(24);
    wr(0, RUN | (32'h20 << 20) | (32'h20 << 12) | (32'h1 << 10)); idle(6);
    // R11: mixed traffic with rotating reads
    tag = "R11"; evtMode = 1; wr(0, RUN | (32'h00 << 20) | (32'h03 << 12) | (32'h7 << 4)); idle(60);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog (all R) actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule